// File: doc/BRIEF.md
# Temperature-Indexed Set-Point Table

This block turns a signed temperature sample into a position in a 36-entry table. Each entry covers a 4 °C band, and the bands span -40 °C to +100 °C. The block then registers the entry found at that position as a set-point code.

Three channels share the same temperature and the same index. Each channel keeps its own table. In the default build, one channel drives a laser power set point and two drive DAC codes.

Temperature arrives as a signed 16-bit fixed-point number in units of 1/256 °C, qualified by a valid strobe. A single write port loads table bytes. It addresses a channel and a byte offset, and the offsets 80h to A3h map to entries 0 to 35. Loaded values reach the outputs only when the next temperature sample arrives.

Top module: `tlut_top`

## Requirements
- R1: Reset clears every table entry, every channel's set-point output and the index output to zero.
- R2: For a sample T in units of 1/256 °C with -10240 <= T < 25600, the index becomes floor((T + 10240) / 1024), which is floor((°C + 40) / 4).
- R3: A sample below -40 °C (T < -10240) yields index 0.
- R4: A sample at or above +100 °C (T >= 25600) yields index 35, up to the largest input 32767.
- R5: The index and set-point outputs change only in the cycle after temp_valid is high. They take the new value one clock after the sample and hold it while temp_valid stays low.
- R6: A write with wr_en high and wr_addr = 80h + k (k from 0 to 35) stores wr_data as entry k of channel wr_chan. A later sample whose index is k then shows that byte on the channel's output.
- R7: A table write alone never changes any output. The written value appears at the next temperature sample.
- R8: A write whose wr_addr lies outside 80h to A3h changes no table entry.
- R9: A write whose wr_chan is not below the channel count (wr_chan = 3 by default) changes no table entry.
- R10: A write to one channel leaves the entries of every other channel unchanged.
- R11: When a write and a sample occur in the same cycle, the sample picks up the entry value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| temp_valid | input | 1 | Marks temp_in as a new sample |
| temp_in | input | 16 | Signed temperature, 1/256 °C per LSB |
| wr_en | input | 1 | Table write strobe |
| wr_chan | input | 2 | Channel addressed by the write |
| wr_addr | input | 8 | Byte offset of the write (80h to A3h are entries) |
| wr_data | input | 8 | Byte to store |
| idx_out | output | 6 | Index chosen by the last sample |
| set_out | output | 24 | Set-point codes, channel c in bits [8c+7:8c] |

## Verification
Several properties are checked on every cycle by assertions: the index never leaves 0 to 35, both clamps hold, and outputs stay still without a sample, whether or not a write is pending. Other behaviour needs the bench's scenarios, because it depends on table contents that the ports only reveal when a sample selects them. That covers exact window boundaries, the stored bytes reaching the right channel, rejected addresses and channels, isolation between channels, and the old-value rule for a write in the same cycle as a sample. The bench loads distinct bytes into every entry and sweeps temperatures across both clamps and every band edge, so that this hidden state shows at the outputs.

// File: rtl/tlut_pkg.sv
package tlut_pkg;
    parameter int TEMP_W   = 16;    // temperature sample width
    parameter int FRAC_W   = 8;     // fractional bits of temperature
    parameter int DATA_W   = 8;     // entry width
    parameter int DEPTH    = 36;    // entries per channel
    parameter int N_CHAN   = 3;     // independent tables
    parameter int ADDR_W   = 8;     // write byte offset width
    parameter int BASE     = 'h80;  // offset of entry 0
    parameter int T_LOW_C  = -40;   // lower edge of band 0 in degrees
    parameter int STEP_C   = 4;     // band width in degrees (power of two)

    localparam int IDX_W   = $clog2(DEPTH);
    localparam int CHAN_W  = (N_CHAN > 1) ? $clog2(N_CHAN + 1) : 1;
endpackage

// File: rtl/tlut_index.sv
module tlut_index
    import tlut_pkg::*;
#(
    parameter int TW    = TEMP_W,
    parameter int FW    = FRAC_W,
    parameter int DEP   = DEPTH,
    parameter int LOW_C = T_LOW_C,
    parameter int STP_C = STEP_C
) (
    input  logic [TW-1:0]            temp,
    output logic [$clog2(DEP)-1:0]   idx
);
    localparam int IW   = $clog2(DEP);
    localparam int BIAS = -(LOW_C * (2 ** FW));      // raw units above band 0 edge
    localparam int SH   = FW + $clog2(STP_C);        // raw units per band as shift
    localparam int TOP  = DEP - 1;

    logic signed [31:0] offs;
    logic signed [31:0] band;

    always_comb begin
        offs = 32'(signed'(temp)) + 32'(BIAS);
        band = offs >>> SH;
        if (offs < 0) begin
            idx = '0;
        end else if (band > 32'(TOP)) begin
            idx = IW'(TOP);
        end else begin
            idx = band[IW-1:0];
        end
    end
endmodule

// File: rtl/tlut_wdec.sv
module tlut_wdec
    import tlut_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int CW  = CHAN_W,
    parameter int NCH = N_CHAN,
    parameter int DEP = DEPTH,
    parameter int BAS = BASE
) (
    input  logic                      wr_en,
    input  logic [CW-1:0]             wr_chan,
    input  logic [AW-1:0]             wr_addr,
    output logic [NCH-1:0]            chan_we,
    output logic [$clog2(DEP)-1:0]    slot
);
    localparam int IW = $clog2(DEP);

    logic [AW:0] rel;
    logic        addr_hit;
    logic        chan_hit;

    always_comb begin
        rel      = {1'b0, wr_addr} - (AW+1)'(BAS);
        addr_hit = (wr_addr >= AW'(BAS)) && (rel < (AW+1)'(DEP));
        chan_hit = (int'(wr_chan) < NCH);
        slot     = rel[IW-1:0];
        for (int c = 0; c < NCH; c++) begin
            chan_we[c] = wr_en && addr_hit && chan_hit && (int'(wr_chan) == c);
        end
    end
endmodule

// File: rtl/tlut_bank.sv
module tlut_bank
    import tlut_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int DEP = DEPTH
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sample,
    input  logic [$clog2(DEP)-1:0]   rd_idx,
    input  logic                     we,
    input  logic [$clog2(DEP)-1:0]   wr_idx,
    input  logic [DW-1:0]            wdata,
    output logic [DW-1:0]            level
);
    typedef struct packed {
        logic [DEP-1:0][DW-1:0] ent;
        logic [DW-1:0]          lvl;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // read uses the table as it stood before this cycle's write
        if (sample) begin
            st_d.lvl = st_q.ent[rd_idx];
        end
        if (we) begin
            st_d.ent[wr_idx] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.lvl;
endmodule

// File: rtl/tlut_top.sv
module tlut_top
    import tlut_pkg::*;
#(
    parameter int TW  = TEMP_W,
    parameter int DW  = DATA_W,
    parameter int DEP = DEPTH,
    parameter int NCH = N_CHAN,
    parameter int AW  = ADDR_W,
    parameter int CW  = CHAN_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     temp_valid,
    input  logic [TW-1:0]            temp_in,
    input  logic                     wr_en,
    input  logic [CW-1:0]            wr_chan,
    input  logic [AW-1:0]            wr_addr,
    input  logic [DW-1:0]            wr_data,
    output logic [$clog2(DEP)-1:0]   idx_out,
    output logic [NCH*DW-1:0]        set_out
);
    localparam int IW = $clog2(DEP);

    typedef struct packed {
        logic [IW-1:0] idx;
    } top_t;

    top_t          tp_d, tp_q;
    logic [IW-1:0] new_idx;
    logic [NCH-1:0] bank_we;
    logic [IW-1:0] bank_slot;

    tlut_index #(.TW(TW), .FW(FRAC_W), .DEP(DEP), .LOW_C(T_LOW_C), .STP_C(STEP_C)) u_index (
        .temp (temp_in),
        .idx  (new_idx)
    );

    tlut_wdec #(.AW(AW), .CW(CW), .NCH(NCH), .DEP(DEP), .BAS(BASE)) u_wdec (
        .wr_en   (wr_en),
        .wr_chan (wr_chan),
        .wr_addr (wr_addr),
        .chan_we (bank_we),
        .slot    (bank_slot)
    );

    always_comb begin
        tp_d = tp_q;
        if (temp_valid) begin
            tp_d.idx = new_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tp_q <= '0;
        end else begin
            tp_q <= tp_d;
        end
    end

    assign idx_out = tp_q.idx;

    for (genvar c = 0; c < NCH; c++) begin : g_bank
        tlut_bank #(.DW(DW), .DEP(DEP)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .sample (temp_valid),
            .rd_idx (new_idx),
            .we     (bank_we[c]),
            .wr_idx (bank_slot),
            .wdata  (wr_data),
            .level  (set_out[c*DW +: DW])
        );
    end
endmodule

// File: rtl/tlut_chk.sv
module tlut_chk #(
    parameter int TW  = 16,
    parameter int DW  = 8,
    parameter int DEP = 36,
    parameter int NCH = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    temp_valid,
    input logic [TW-1:0]           temp_in,
    input logic                    wr_en,
    input logic [$clog2(DEP)-1:0]  idx_out,
    input logic [NCH*DW-1:0]       set_out
);
    localparam int LOW_RAW  = -10240;   // -40 degrees in 1/256 units
    localparam int HIGH_RAW = 25600;    // +100 degrees in 1/256 units

    // R2: index stays inside the table
    p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(idx_out) <= DEP - 1);

    // R3: cold samples clamp to entry 0
    p_low_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_valid && int'(signed'(temp_in)) < LOW_RAW) |=> (idx_out == '0));

    // R4: hot samples clamp to the last entry
    p_high_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_valid && int'(signed'(temp_in)) >= HIGH_RAW) |=> (int'(idx_out) == DEP - 1));

    // R5: no sample, no change
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !temp_valid |=> ($stable(idx_out) && $stable(set_out)));

    // R7: a lone write leaves the set points alone
    p_write_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !temp_valid) |=> $stable(set_out));
endmodule

bind tlut_top tlut_chk #(.TW(TW), .DW(DW), .DEP(DEP), .NCH(NCH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .temp_valid (temp_valid),
    .temp_in    (temp_in),
    .wr_en      (wr_en),
    .idx_out    (idx_out),
    .set_out    (set_out)
);

// File: tb/sim_tlut_top.sv
module sim_tlut_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        temp_valid = 1'b0;
    logic [15:0] temp_in = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_chan = '0;
    logic [7:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [5:0]  idx_out;
    logic [23:0] set_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int mem [3][36];
    int e_idx;
    int e_set [3];

    always #5 clk = ~clk;

    tlut_top u0 (
        .clk(clk), .rst_n(rst_n), .temp_valid(temp_valid), .temp_in(temp_in),
        .wr_en(wr_en), .wr_chan(wr_chan), .wr_addr(wr_addr), .wr_data(wr_data),
        .idx_out(idx_out), .set_out(set_out)
    );

    // band search: last band whose lower edge is at or below t
    function automatic int ref_band(input int t);
        int b = 0;
        for (int k = 0; k < 36; k++) begin
            if (t >= -10240 + k * 1024) b = k;
        end
        return b;
    endfunction

    task automatic compare(input string tag);
        checks++;
        if (int'(idx_out) != e_idx) begin
            errors++;
            $display("FAIL %s idx_out act=%0d exp=%0d", tag, idx_out, e_idx);
        end
        for (int c = 0; c < 3; c++) begin
            checks++;
            if (int'(set_out[c*8 +: 8]) != e_set[c]) begin
                errors++;
                $display("FAIL %s set_out[%0d] act=%0d exp=%0d", tag, c, set_out[c*8 +: 8], e_set[c]);
            end
        end
    endtask

    task automatic cyc(input bit v, input int t, input bit we, input int ch,
                       input int a, input int d, input string tag);
        @(negedge clk);
        temp_valid = v;
        temp_in    = 16'(t);
        wr_en      = we;
        wr_chan    = 2'(ch);
        wr_addr    = 8'(a);
        wr_data    = 8'(d);
        if (v) begin
            e_idx = ref_band(t);
            for (int c = 0; c < 3; c++) e_set[c] = mem[c][e_idx];
        end
        if (we && ch < 3 && a >= 'h80 && a <= 'hA3) mem[ch][a - 'h80] = d & 255;
        @(posedge clk);
        #1;
        compare(tag);
    endtask

    task automatic idle(input string tag);
        cyc(0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic sample(input int t, input string tag);
        cyc(1, t, 0, 0, 0, 0, tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 3; c++) begin
            e_set[c] = 0;
            for (int k = 0; k < 36; k++) mem[c][k] = 0;
        end
        e_idx = 0;
        repeat (3) @(posedge clk);
        #1;
        compare("R1 reset");
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        compare("R1 after release");

        // R1: untouched table reads zero
        sample(0, "R1 empty table");

        // R6 R7 R10: fill all tables with distinct bytes, outputs must not move
        for (int c = 0; c < 3; c++)
            for (int k = 0; k < 36; k++)
                cyc(0, 0, 1, c, 'h80 + k, (c * 83 + k * 7 + 1) & 255, "R7 write only");

        // R2: band edges and interior points
        sample(-10240, "R2 band0 edge");
        sample(-10239, "R2 band0 inner");
        sample(-9217,  "R2 below band1");
        sample(-9216,  "R2 band1 edge");
        sample(25 * 256, "R2 25C");
        sample(0, "R2 0C");
        sample(25599, "R2 top of band34");
        // R3 low clamp
        sample(-10241, "R3 just below");
        sample(-41 * 256, "R3 -41C");
        sample(-32768, "R3 most negative");
        // R4 high clamp
        sample(25600, "R4 100C");
        sample(26000, "R4 above");
        sample(32767, "R4 max");
        // R2 sweep across every band and both clamps
        for (int t = -11000; t < 27000; t += 331) sample(t, "R2 sweep");

        // R5: hold without samples
        sample(12 * 256, "R5 load");
        repeat (4) idle("R5 hold");

        // R8: offsets outside the table window
        cyc(0, 0, 1, 0, 'h7F, 8'hEE, "R8 addr 7F");
        cyc(0, 0, 1, 0, 'hA4, 8'hEE, "R8 addr A4");
        cyc(0, 0, 1, 1, 'h00, 8'hEE, "R8 addr 00");
        sample(-10240, "R8 entry0 intact");
        sample(25600, "R8 entry35 intact");

        // R9: channel 3 does not exist
        cyc(0, 0, 1, 3, 'h80, 8'h5A, "R9 write ch3");
        cyc(0, 0, 1, 3, 'hA3, 8'h5A, "R9 write ch3");
        sample(-20000, "R9 tables intact");
        sample(30000, "R9 tables intact");

        // R10: one channel only
        cyc(0, 0, 1, 1, 'h80 + 20, 8'hC3, "R10 write ch1");
        sample(20 * 1024 - 10240, "R10 only ch1 changed");

        // R11: write and sample together
        cyc(1, 5 * 1024 - 10240, 1, 2, 'h80 + 5, 8'h99, "R11 same cycle old value");
        sample(5 * 1024 - 10240, "R11 next sample new value");

        // R6: rewrite each entry of channel 0 and read it back
        for (int k = 0; k < 36; k += 5) begin
            cyc(0, 0, 1, 0, 'h80 + k, 255 - k, "R6 rewrite");
            sample(k * 1024 - 10240 + 512, "R6 readback");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule